// File: doc/BRIEF.md
# Serial Display Write Receiver

This block receives a write-only, four-wire serial stream for a display controller. While the chip-select line is low, each rising edge of the serial clock shifts one bit of the data line into a shift register, most significant bit first. The data/command select line is sampled on the eighth rising edge of each byte. In the system clock cycle that follows that edge, the finished byte is handed to one of two destinations: the command decoder or the display-memory write port.

All four serial pins are brought into the system clock domain through flop synchronizers, and serial clock edges are detected there. Raising chip-select drops any partial byte. Holding chip-select low lets bytes follow one another without a gap. The serial path has no read direction.

Top module: `sdw_serial_wr`

## Requirements
- R1: While reset is asserted, and after it is released with no traffic, `cmd_vld_o` and `dat_vld_o` are 0 and `byte_o` is all zeros.
- R2: Bits are assembled most significant first: the bit sampled on the first rising serial clock edge of a byte appears in `byte_o[7]` and the bit of the eighth edge in `byte_o[0]`.
- R3: The data/command line is sampled only on the eighth edge of a byte. A 1 there selects the display-memory port (`dat_vld_o`) and a 0 selects the command port (`cmd_vld_o`). Its value on the first seven edges has no effect.
- R4: Each completed byte produces exactly one strobe, one system clock cycle wide, on exactly one of `cmd_vld_o` and `dat_vld_o`. The two strobes are never high together.
- R5: A strobe is raised only in the system clock cycle that follows a detected eighth rising serial clock edge. Fewer than eight edges produce no strobe.
- R6: Chip-select high clears the bit counter, so a partial byte is discarded and the next byte starts again at bit 7.
- R7: With chip-select held low, the bit counter wraps after the eighth bit and the next edges assemble a new byte with no extra clocks.
- R8: Serial clock edges while chip-select is high shift nothing and advance nothing.
- R9: `byte_o` holds the last delivered byte in every cycle without a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock pin, asynchronous |
| sdin_i | input | 1 | Serial data pin |
| csn_i | input | 1 | Active-low chip select pin |
| dc_i | input | 1 | Data (1) / command (0) select pin |
| cmd_vld_o | output | 1 | One-cycle strobe: `byte_o` is a command byte |
| dat_vld_o | output | 1 | One-cycle strobe: `byte_o` is a display-memory byte |
| byte_o | output | DATA_W (8) | Last completed byte |

## Verification
The hardest case to reach from the ports is a frame cut short. Chip-select must rise after some but not all of the eight edges, and the next frame must then be shown to start cleanly at bit 7. The random stimulus therefore sometimes sends a truncated byte of one to seven bits before releasing chip-select. It also toggles the serial clock with chip-select high, and it toggles the data/command line during the first seven bits. Any stray strobe or misaligned byte shows up against the bench's queue of expected bytes.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

   // Bundle of the four serial pins, used on both sides of the synchronizer
   typedef struct packed {
      logic sclk;
      logic sdin;
      logic csn;
      logic dc;
   } sdw_pins_t;

   localparam int unsigned PIN_W = $bits(sdw_pins_t);

   // Idle pin levels: chip select released, clock low
   localparam sdw_pins_t PIN_IDLE = '{sclk: 1'b0, sdin: 1'b0, csn: 1'b1, dc: 1'b0};

   function automatic int unsigned cnt_width(input int unsigned nbits);
      return (nbits <= 2) ? 1 : $clog2(nbits);
   endfunction

endpackage

// File: rtl/sdw_sync.sv
module sdw_sync #(
   parameter int unsigned         W       = 4,
   parameter int unsigned         STAGES  = 2,
   parameter logic [W-1:0]        RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_i,
   output logic [W-1:0] sync_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("sdw_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= RST_VAL;
            else        chain_q[0] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= RST_VAL;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/sdw_edge.sv
module sdw_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_s,
   input  logic csn_s,
   output logic rise_o
);

   logic sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_q <= 1'b0;
      else        sclk_q <= sclk_s;
   end

   // Only edges inside an active frame count
   assign rise_o = sclk_s & ~sclk_q & ~csn_s;

endmodule

// File: rtl/sdw_shift.sv
module sdw_shift #(
   parameter int unsigned DATA_W    = 8,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rise_i,
   input  logic              sdin_s,
   input  logic              dc_s,
   input  logic              csn_s,
   output logic              cmd_vld_o,
   output logic              dat_vld_o,
   output logic [DATA_W-1:0] byte_o,
   output logic [sdw_pkg::cnt_width(DATA_W)-1:0] cnt_o
);

   localparam int unsigned CW   = sdw_pkg::cnt_width(DATA_W);
   localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

   logic [DATA_W-1:0] sh_q;
   logic [DATA_W-1:0] sh_next;
   logic [CW-1:0]     cnt_q;
   logic              last_bit;

   // The shift direction is picked at elaboration
   if (MSB_FIRST) begin : g_msb
      assign sh_next = {sh_q[DATA_W-2:0], sdin_s};
   end else begin : g_lsb
      assign sh_next = {sdin_s, sh_q[DATA_W-1:1]};
   end

   assign last_bit = (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else if (csn_s) begin
         cnt_q <= '0;
      end else if (rise_i) begin
         sh_q  <= sh_next;
         cnt_q <= last_bit ? '0 : cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_o    <= '0;
         cmd_vld_o <= 1'b0;
         dat_vld_o <= 1'b0;
      end else begin
         cmd_vld_o <= 1'b0;
         dat_vld_o <= 1'b0;
         if (!csn_s && rise_i && last_bit) begin
            byte_o    <= sh_next;
            cmd_vld_o <= ~dc_s;
            dat_vld_o <= dc_s;
         end
      end
   end

   assign cnt_o = cnt_q;

endmodule

// File: rtl/sdw_serial_wr.sv
module sdw_serial_wr #(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          MSB_FIRST   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_i,
   input  logic              sdin_i,
   input  logic              csn_i,
   input  logic              dc_i,
   output logic              cmd_vld_o,
   output logic              dat_vld_o,
   output logic [DATA_W-1:0] byte_o
);
   import sdw_pkg::*;

   localparam int unsigned CW = cnt_width(DATA_W);

   if (DATA_W < 2) begin : g_bad_width
      $error("sdw_serial_wr: DATA_W must be at least 2");
   end

   sdw_pins_t     pins_raw, pins_s;
   logic          sclk_rise;
   logic [CW-1:0] bit_cnt;

   assign pins_raw = '{sclk: sclk_i, sdin: sdin_i, csn: csn_i, dc: dc_i};

   sdw_sync #(
      .W      (PIN_W),
      .STAGES (SYNC_STAGES),
      .RST_VAL(PIN_IDLE)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .async_i(pins_raw),
      .sync_o (pins_s)
   );

   sdw_edge u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .sclk_s(pins_s.sclk),
      .csn_s (pins_s.csn),
      .rise_o(sclk_rise)
   );

   sdw_shift #(
      .DATA_W   (DATA_W),
      .MSB_FIRST(MSB_FIRST)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .rise_i   (sclk_rise),
      .sdin_s   (pins_s.sdin),
      .dc_s     (pins_s.dc),
      .csn_s    (pins_s.csn),
      .cmd_vld_o(cmd_vld_o),
      .dat_vld_o(dat_vld_o),
      .byte_o   (byte_o),
      .cnt_o    (bit_cnt)
   );

endmodule

// File: rtl/sdw_serial_wr_chk.sv
module sdw_serial_wr_chk #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned CW     = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_vld_o,
   input logic              dat_vld_o,
   input logic [DATA_W-1:0] byte_o,
   input logic              rise,
   input logic              csn_s,
   input logic [CW-1:0]     cnt
);

   AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd_vld_o, dat_vld_o}));                                   // R4
   AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_vld_o || dat_vld_o) |=> !(cmd_vld_o || dat_vld_o));             // R4
   AST_STROBE_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_vld_o || dat_vld_o) |-> $past(rise));                           // R5
   AST_CS_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      csn_s |=> (cnt == '0));                                              // R6
   AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_vld_o || dat_vld_o) |-> $stable(byte_o));                      // R9
   AST_NO_SHIFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      csn_s |-> !rise);                                                    // R8

endmodule

bind sdw_serial_wr sdw_serial_wr_chk #(
   .DATA_W(DATA_W),
   .CW    (CW)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cmd_vld_o(cmd_vld_o),
   .dat_vld_o(dat_vld_o),
   .byte_o   (byte_o),
   .rise     (sclk_rise),
   .csn_s    (pins_s.csn),
   .cnt      (bit_cnt)
);

// File: tb/test_sdw_serial_wr.sv
`timescale 1ns/1ps
module test_sdw_serial_wr;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sclk = 1'b0, sdin = 1'b0, csn = 1'b1, dc = 1'b0;
   logic       cmd_vld, dat_vld;
   logic [7:0] byte_q;

   int unsigned n_cmp = 0, n_bad = 0;
   int unsigned exp_n = 0, got_n = 0, cyc = 0;
   logic [7:0]  exp_byte [256];
   logic        exp_dc   [256];
   logic        prev_stb = 1'b0;

   always #5 clk = ~clk;

   sdw_serial_wr i_sdw_serial_wr (
      .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdin_i(sdin),
      .csn_i(csn), .dc_i(dc),
      .cmd_vld_o(cmd_vld), .dat_vld_o(dat_vld), .byte_o(byte_q)
   );

   function automatic logic [1:0] exp_route(input logic d);
      return d ? 2'b10 : 2'b01;   // {dat, cmd}
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
   endtask

   // One serial bit: data set while clock is low, then a rising edge
   task automatic send_bit(input logic b, input logic d);
      sdin = b; dc = d; sclk = 1'b0;
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
   endtask

   // R3: dc is random on the first seven bits, the real value on the eighth
   task automatic send_byte(input logic [7:0] b, input logic d, input bit noisy_dc);
      exp_byte[exp_n] = b;
      exp_dc[exp_n]   = d;
      exp_n++;
      for (int i = 7; i >= 0; i--)
         send_bit(b[i], (i == 0 || !noisy_dc) ? d : logic'($urandom_range(0, 1)));
   endtask

   task automatic cs_low();
      csn = 1'b0; wait_clk(4);
   endtask

   task automatic cs_high();
      wait_clk(2); csn = 1'b1; wait_clk(6);
   endtask

   // Monitor at the falling edge, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         cyc++;
         if (cmd_vld || dat_vld) begin
            check(!prev_stb, "R4 width", 1, 0);
            check(!(cmd_vld && dat_vld), "R4 onehot", {dat_vld, cmd_vld}, 0);
            if (got_n < exp_n) begin
               check(byte_q == exp_byte[got_n], "R2/R7 byte", byte_q, exp_byte[got_n]);
               check({dat_vld, cmd_vld} == exp_route(exp_dc[got_n]), "R3 route",
                     {dat_vld, cmd_vld}, exp_route(exp_dc[got_n]));
            end else begin
               check(1'b0, "R5/R6/R8 stray strobe", byte_q, 0);
            end
            got_n++;
         end
         prev_stb = cmd_vld || dat_vld;
         if (cyc > 150000) begin
            check(1'b0, "watchdog", cyc, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
         end
      end
   end

   initial begin
      void'($urandom(32'h5D30_1A7E));
      wait_clk(3);
      #1;
      check(cmd_vld == 0 && dat_vld == 0, "R1 strobes in reset", {cmd_vld, dat_vld}, 0);
      check(byte_q == 8'h00, "R1 byte in reset", byte_q, 0);
      rst_n = 1'b1;
      wait_clk(5);
      #1;
      check(byte_q == 8'h00 && !cmd_vld && !dat_vld, "R1 idle after reset", byte_q, 0);

      // R2: bit-order corner patterns
      cs_low();
      send_byte(8'h80, 1'b0, 1'b0);
      send_byte(8'h01, 1'b1, 1'b0);
      cs_high();

      // R8: clock toggles with chip select released
      for (int i = 0; i < 8; i++) send_bit(1'b1, 1'b1);
      cs_low();
      send_byte(8'h3C, 1'b1, 1'b0);   // must start cleanly at bit 7
      cs_high();

      // R6: partial byte then a full one
      cs_low();
      for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b0);
      cs_high();
      cs_low();
      send_byte(8'h5A, 1'b0, 1'b0);
      cs_high();

      // R7 and R3: random bytes, back to back, noisy dc, random truncations
      cs_low();
      for (int k = 0; k < 48; k++) begin
         int unsigned r = $urandom_range(0, 7);
         if (r == 0) begin
            cs_high();
            cs_low();
         end else if (r == 1) begin
            int unsigned nb = $urandom_range(1, 7);
            for (int i = 0; i < int'(nb); i++) send_bit(logic'($urandom_range(0, 1)), 1'b0);
            cs_high();
            cs_low();
         end
         send_byte(8'($urandom), logic'($urandom_range(0, 1)), 1'b1);
      end
      cs_high();
      wait_clk(10);

      check(got_n == exp_n, "R5 strobe count", got_n, exp_n);
      #1;
      check(!cmd_vld && !dat_vld, "R9 quiet end", {cmd_vld, dat_vld}, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule